// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Controller

This block collects up to 32 peripheral event inputs (24 by default) and reports them to a host over two separate interrupt lines. Every source input is brought into the clock domain by a two-flop synchroniser. Its edges are then detected according to a per-source edge-select field, which can pick rising edges, falling edges, both, or neither. The edge-select fields are shared by both lines. Each detected event is latched into one private status register per line. Each line also has its own mask register, and the line asserts its active-low interrupt output while any unmasked status bit is set. An active-high copy of the same condition goes to a primary aggregator.

The host reaches all registers through a byte-wide port with a combinational read path. A control register selects how status is acknowledged. In one mode, a read of a status byte clears the bits it returned. In the other mode, the host writes ones to the bits it wants to clear. The control register also selects whether a second event on a source whose status bit is still set is kept in a one-deep buffer or dropped. An event that arrives in the same cycle as the clear of its status bit is never lost.

Top module: `sec_irq_dual`

## Requirements
- R1: A level change on `src_in[i]` that is driven between two clock edges is detected as an edge at the third rising clock edge after that change. The resulting status bit is readable from that edge onward.
- R2: Source i owns two edge-select bits in the edge-select byte at address 0x08 + i/4. Bit (i mod 4)*2+1 enables rising-edge detection and bit (i mod 4)*2 enables falling-edge detection. The edge-select bytes read back exactly as written.
- R3: A source whose two edge-select bits are both 0 never sets a status bit on either line, however its input toggles.
- R4: Line 0 has status bytes at 0x10.. and mask bytes at 0x14... Line 1 has status bytes at 0x18.. and mask bytes at 0x1C... Every detected event sets the source's status bit on both lines. Acknowledging or masking on one line leaves the other line untouched.
- R5: After reset, all mask bits read 1, all edge-select and status bits read 0, the control byte at 0x00 reads 0, and both `irq_n` bits are 1.
- R6: Status and mask bytes are little-endian, with source i at bit i mod 8 of byte i/8. Reads of unmapped addresses return 0x00.
- R7: Control bit 0 set selects clear-on-read. A read of a status byte clears the bits it returned, and writes to status bytes are ignored. Control bit 0 clear selects write-one-to-clear. Writing 1 to a status bit clears it, and reads leave status unchanged.
- R8: With control bit 1 at 0, an event on a source whose status bit is set and not being cleared is buffered, and the status bit is set again once it has been cleared. With control bit 1 at 1, such an event is dropped. A status bit only becomes set because of an event or a buffered event.
- R9: An event in the same cycle as a clear of its status bit wins, and the bit remains set.
- R10: `irq_n[l]` is 0 and `line_pending[l]` is 1 exactly while some bit of line l's status AND NOT mask is 1.
- R11: Status bits latch whether or not they are masked. Clearing a mask bit later asserts the line for an already pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Peripheral event inputs, asynchronous |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle; the clear-on-read side effect occurs at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq_n | output | 2 | Active-low interrupt, one per host line |
| line_pending | output | 2 | Active-high per-line summary for the primary aggregator |

## Verification
The assertions take for granted that the host never raises `bus_rd` and `bus_wr` in the same cycle. They also assume that the reset is asserted long enough for the synchroniser and status flops to start at zero. The stimulus issues at most one bus operation per cycle and changes the sources and bus only on the falling clock edge. In the random phase it toggles sources freely, including within the same cycle as reads and writes of the status bytes, so that the event-versus-clear collision and the buffering paths are driven often in both acknowledgement modes.

// File: rtl/sih2_pkg.sv
package sih2_pkg;
  localparam int ADDR_W    = 5;
  localparam int NUM_LINES = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_EDGE  = 5'h08;
  localparam logic [ADDR_W-1:0] A_STAT0 = 5'h10;
  localparam logic [ADDR_W-1:0] A_MASK0 = 5'h14;
  localparam logic [ADDR_W-1:0] A_STAT1 = 5'h18;
  localparam logic [ADDR_W-1:0] A_MASK1 = 5'h1C;

  localparam int CTRL_COR_BIT   = 0;
  localparam int CTRL_NOBUF_BIT = 1;

  // number of bytes needed to hold nbits
  function automatic int byte_count(input int nbits);
    return (nbits + 7) / 8;
  endfunction

  // position of a source's rising / falling enable in the flat edge vector
  function automatic int rise_pos(input int src);
    return 2 * src + 1;
  endfunction

  function automatic int fall_pos(input int src);
    return 2 * src;
  endfunction

  function automatic logic [ADDR_W-1:0] stat_base(input int line);
    return (line == 0) ? A_STAT0 : A_STAT1;
  endfunction

  function automatic logic [ADDR_W-1:0] mask_base(input int line);
    return (line == 0) ? A_MASK0 : A_MASK1;
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int idx);
    return a == (base + ADDR_W'(idx));
  endfunction
endpackage

// File: rtl/sih_edge_detect.sv
module sih_edge_detect #(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] rise_en,
  input  logic [NUM_SRC-1:0] fall_en,
  output logic [NUM_SRC-1:0] evt
);
  logic [NUM_SRC-1:0] s1_q, s2_q, prev_q;
  logic [NUM_SRC-1:0] rise_seen, fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= src_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_seen = s2_q & ~prev_q;
  assign fall_seen = ~s2_q & prev_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign evt[i] = (rise_en[i] & rise_seen[i]) | (fall_en[i] & fall_seen[i]);
  end

  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~(s2_q ^ prev_q)) == '0); // R1
endmodule

// File: rtl/sih_line_state.sv
module sih_line_state #(
  parameter int NUM_SRC = 24,
  parameter int SB      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr,
  input  logic               no_buf,
  input  logic [SB-1:0]      mask_we,
  input  logic [7:0]         wdata,
  output logic [SB*8-1:0]    status,
  output logic [SB*8-1:0]    mask,
  output logic               req
);
  logic [NUM_SRC-1:0] stat_q, stat_d, pend_q, pend_d;
  logic [SB*8-1:0]    mask_q;

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (evt[i]) begin
        stat_d[i] = 1'b1;
        if (stat_q[i] && !clr[i] && !no_buf) pend_d[i] = 1'b1;
      end else if (clr[i]) begin
        stat_d[i] = pend_q[i];
        pend_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
      for (int b = 0; b < SB; b++) begin
        if (mask_we[b]) mask_q[b*8 +: 8] <= wdata;
      end
    end
  end

  assign status = (SB*8)'(stat_q);
  assign mask   = mask_q;
  assign req    = |(stat_q & ~mask_q[NUM_SRC-1:0]);

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt))); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~evt & ~pend_q)) |=> ((stat_q & $past(clr & ~evt & ~pend_q)) == '0)); // R7
  AST_SET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt) & ~$past(pend_q)) == '0)); // R8
  AST_NOBUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf |=> ((pend_q & ~$past(pend_q)) == '0)); // R8
endmodule

// File: rtl/sec_irq_dual.sv
module sec_irq_dual
  import sih2_pkg::*;
#(
  parameter int NUM_SRC = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic [NUM_LINES-1:0] irq_n,
  output logic [NUM_LINES-1:0] line_pending
);
  localparam int SB = byte_count(NUM_SRC);
  localparam int EB = byte_count(2 * NUM_SRC);

  logic               cor_q, nobuf_q;
  logic [EB*8-1:0]    edge_q;
  logic [NUM_SRC-1:0] rise_en, fall_en, evt;
  logic [SB*8-1:0]    stat_v [NUM_LINES];
  logic [SB*8-1:0]    mask_v [NUM_LINES];
  logic [NUM_LINES-1:0] req;

  // control and shared edge-select registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cor_q   <= 1'b0;
      nobuf_q <= 1'b0;
      edge_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        cor_q   <= bus_wdata[CTRL_COR_BIT];
        nobuf_q <= bus_wdata[CTRL_NOBUF_BIT];
      end
      for (int b = 0; b < EB; b++) begin
        if (addr_hit(bus_addr, A_EDGE, b)) edge_q[b*8 +: 8] <= bus_wdata;
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign rise_en[i] = edge_q[rise_pos(i)];
    assign fall_en[i] = edge_q[fall_pos(i)];
  end

  sih_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (src_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .evt     (evt)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [SB*8-1:0] clr_full;
    logic [SB-1:0]   mask_we;

    for (genvar b = 0; b < SB; b++) begin : g_byte
      logic stat_hit;
      assign stat_hit = addr_hit(bus_addr, stat_base(l), b);
      assign clr_full[b*8 +: 8] = stat_hit
        ? ({8{bus_rd & cor_q}} | ({8{bus_wr & ~cor_q}} & bus_wdata))
        : 8'h00;
      assign mask_we[b] = bus_wr & addr_hit(bus_addr, mask_base(l), b);
    end

    sih_line_state #(.NUM_SRC(NUM_SRC), .SB(SB)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .clr     (clr_full[NUM_SRC-1:0]),
      .no_buf  (nobuf_q),
      .mask_we (mask_we),
      .wdata   (bus_wdata),
      .status  (stat_v[l]),
      .mask    (mask_v[l]),
      .req     (req[l])
    );
  end

  // combinational read path
  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == A_CTRL) begin
      bus_rdata[CTRL_COR_BIT]   = cor_q;
      bus_rdata[CTRL_NOBUF_BIT] = nobuf_q;
    end
    for (int b = 0; b < EB; b++) begin
      if (addr_hit(bus_addr, A_EDGE, b)) bus_rdata = edge_q[b*8 +: 8];
    end
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int b = 0; b < SB; b++) begin
        if (addr_hit(bus_addr, stat_base(l), b)) bus_rdata = stat_v[l][b*8 +: 8];
        if (addr_hit(bus_addr, mask_base(l), b)) bus_rdata = mask_v[l][b*8 +: 8];
      end
    end
  end

  assign irq_n        = ~req;
  assign line_pending = req;
endmodule

// File: tb/sec_irq_dual_tb_top.sv
module sec_irq_dual_tb_top;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  irq_n, line_pending;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sec_irq_dual #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n), .line_pending(line_pending));

  // behavioural reference model
  bit         m_cor, m_nobuf;
  bit [47:0]  m_edge;
  bit [N-1:0] m_stat [2];
  bit [N-1:0] m_pend [2];
  bit [N-1:0] m_mask [2];
  bit [N-1:0] hist [3];   // hist[k]: input sampled k+1 edges ago

  function automatic bit [7:0] m_read(input bit [4:0] a);
    int ai = int'(a);
    if (ai == 0) return {6'b0, m_nobuf, m_cor};
    if (ai >= 8  && ai < 14) return m_edge[(ai-8)*8 +: 8];
    if (ai >= 16 && ai < 19) return m_stat[0][(ai-16)*8 +: 8];
    if (ai >= 20 && ai < 23) return m_mask[0][(ai-20)*8 +: 8];
    if (ai >= 24 && ai < 27) return m_stat[1][(ai-24)*8 +: 8];
    if (ai >= 28 && ai < 31) return m_mask[1][(ai-28)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic bit [1:0] m_req();
    bit [1:0] r;
    for (int l = 0; l < 2; l++) r[l] = |(m_stat[l] & ~m_mask[l]);
    return r;
  endfunction

  always @(posedge clk) begin : model
    bit [N-1:0] ev;
    bit clr;
    int sa;
    if (!rst_n) begin
      m_cor = 0; m_nobuf = 0; m_edge = '0;
      for (int l = 0; l < 2; l++) begin
        m_stat[l] = '0; m_pend[l] = '0; m_mask[l] = '1;
      end
      for (int k = 0; k < 3; k++) hist[k] = '0;
    end else begin
      for (int i = 0; i < N; i++)
        ev[i] = (m_edge[2*i+1] && hist[1][i] && !hist[2][i]) ||
                (m_edge[2*i]   && !hist[1][i] && hist[2][i]);
      for (int l = 0; l < 2; l++) begin
        for (int i = 0; i < N; i++) begin
          sa  = (l == 0 ? 16 : 24) + i / 8;
          clr = 0;
          if (int'(bus_addr) == sa) begin
            if (bus_rd && m_cor) clr = 1;
            if (bus_wr && !m_cor && bus_wdata[i % 8]) clr = 1;
          end
          if (ev[i]) begin
            if (m_stat[l][i] && !clr && !m_nobuf) m_pend[l][i] = 1;
            m_stat[l][i] = 1;
          end else if (clr) begin
            m_stat[l][i] = m_pend[l][i];
            m_pend[l][i] = 0;
          end
        end
      end
      if (bus_wr) begin
        sa = int'(bus_addr);
        if (sa == 0) begin m_cor = bus_wdata[0]; m_nobuf = bus_wdata[1]; end
        if (sa >= 8  && sa < 14) m_edge[(sa-8)*8 +: 8] = bus_wdata;
        if (sa >= 20 && sa < 23) m_mask[0][(sa-20)*8 +: 8] = bus_wdata;
        if (sa >= 28 && sa < 31) m_mask[1][(sa-28)*8 +: 8] = bus_wdata;
      end
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = src_in;
    end
  end

  task automatic check8(input bit [7:0] got, input bit [7:0] exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  // line outputs compared every cycle (R10)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check8({6'b0, irq_n}, {6'b0, ~m_req()}, "R10 irq_n");
      check8({6'b0, line_pending}, {6'b0, m_req()}, "R10 line_pending");
    end
  end

  task automatic op_idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
    end
  endtask

  task automatic op_write(input bit [4:0] a, input bit [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
  endtask

  task automatic op_read(input bit [4:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1; bus_wr = 0;
    #1 check8(bus_rdata, m_read(a), tag);
  endtask

  task automatic set_src(input bit [N-1:0] v);
    @(negedge clk);
    src_in = v; bus_rd = 0; bus_wr = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check8({6'b0, irq_n}, 8'h03, "R5 irq_n after reset");
    // R5 reset contents
    op_read(5'h00, "R5 ctrl");
    for (int b = 0; b < 3; b++) op_read(5'h14 + 5'(b), "R5 mask line0");
    for (int b = 0; b < 3; b++) op_read(5'h1C + 5'(b), "R5 mask line1");
    for (int b = 0; b < 6; b++) op_read(5'h08 + 5'(b), "R5 edge");
    op_read(5'h10, "R5 status");

    // R2 edge programming: src0 rise, src5 fall, src9 both, src12 none, src23 rise
    op_write(5'h08, 8'h02);
    op_write(5'h09, 8'h04);
    op_write(5'h0A, 8'h0C);
    op_write(5'h0D, 8'h80);
    for (int b = 0; b < 6; b++) op_read(5'h08 + 5'(b), "R2 edge readback");
    op_read(5'h07, "R6 unmapped");

    // R11/R4: unmask src0 on line0 only
    op_write(5'h14, 8'hFE);
    set_src(24'h000001);
    op_idle(4);
    op_read(5'h10, "R4 line0 status");
    op_read(5'h18, "R11 line1 status latched while masked");
    #1 check8({6'b0, irq_n}, 8'h02, "R10 line0 low line1 high");

    // R1 latency on src23 (status byte 2, bit 7)
    set_src(24'h800001);
    op_read(5'h12, "R1 one edge after change");
    op_read(5'h12, "R1 two edges after change");
    op_read(5'h12, "R1 three edges after change");
    op_read(5'h1A, "R6 line1 byte2");

    // R3: src12 toggles without edge enables
    set_src(24'h801001); op_idle(4);
    set_src(24'h800001); op_idle(4);
    op_read(5'h11, "R3 disabled source");
    op_read(5'h19, "R3 disabled source line1");

    // R7 write-one-to-clear, reads do not clear
    op_read(5'h10, "R7 read keeps status");
    op_write(5'h10, 8'h01);
    op_read(5'h10, "R7 w1c cleared");
    op_read(5'h18, "R4 line1 untouched by line0 clear");

    // R8 buffering of a second src5 falling event
    set_src(24'h800021); op_idle(4);
    set_src(24'h800001); op_idle(4);
    set_src(24'h800021); op_idle(4);
    set_src(24'h800001); op_idle(4);
    op_write(5'h10, 8'h20);
    op_read(5'h10, "R8 buffered event returns");
    op_write(5'h10, 8'h20);
    op_read(5'h10, "R8 cleared after buffer drained");
    op_write(5'h00, 8'h02);
    set_src(24'h800021); op_idle(4);
    set_src(24'h800001); op_idle(4);
    set_src(24'h800021); op_idle(4);
    set_src(24'h800001); op_idle(4);
    op_write(5'h10, 8'h20);
    op_read(5'h10, "R8 second event dropped");

    // R7 clear-on-read
    op_write(5'h00, 8'h01);
    set_src(24'h800201); op_idle(4);
    op_read(5'h11, "R7 cor returns set bits");
    op_read(5'h11, "R7 cor cleared by read");
    set_src(24'h800001); op_idle(4);
    op_write(5'h11, 8'hFF);
    op_read(5'h11, "R7 write ignored in cor mode");

    // R9 event collides with clear-on-read of a set bit
    set_src(24'h800000); op_idle(4);
    op_read(5'h10, "R9 setup drain");
    set_src(24'h800001); op_idle(4);
    set_src(24'h800000); op_idle(3);
    set_src(24'h800001);
    op_idle(1);
    op_read(5'h10, "R9 read during event");
    op_read(5'h10, "R9 bit kept after collision");
    // R9 in write-one-to-clear mode
    op_write(5'h00, 8'h00);
    set_src(24'h800000); op_idle(3);
    set_src(24'h800001);
    op_idle(1);
    op_write(5'h10, 8'h01);
    op_read(5'h10, "R9 w1c collision");

    // R11: unmask line1 later
    op_write(5'h1C, 8'h00);
    op_idle(1);
    #1 check8({6'b0, irq_n}, {6'b0, ~m_req()}, "R11 line1 asserts on unmask");
    op_read(5'h1C, "R6 mask line1 byte0");

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int k = $urandom_range(0, 99);
      @(negedge clk);
      bus_rd = 0; bus_wr = 0;
      if ($urandom_range(0, 2) == 0) src_in = src_in ^ N'($urandom) ^ N'($urandom);
      if (k < 35) begin
        bus_addr = 5'($urandom_range(0, 31)); bus_rd = 1;
        #1 check8(bus_rdata, m_read(bus_addr), "R6 random read");
      end else if (k < 55) begin
        bus_addr = ($urandom_range(0, 1) == 0 ? 5'h10 : 5'h18) + 5'($urandom_range(0, 2));
        bus_wdata = 8'($urandom); bus_wr = 1;
      end else if (k < 62) begin
        bus_addr = ($urandom_range(0, 1) == 0 ? 5'h14 : 5'h1C) + 5'($urandom_range(0, 2));
        bus_wdata = 8'($urandom); bus_wr = 1;
      end else if (k < 67) begin
        bus_addr = 5'h08 + 5'($urandom_range(0, 5));
        bus_wdata = 8'($urandom); bus_wr = 1;
      end else if (k < 70) begin
        bus_addr = 5'h00; bus_wdata = 8'($urandom_range(0, 3)); bus_wr = 1;
      end
    end
    op_idle(2);
    for (int b = 0; b < 32; b++) op_read(5'(b), "R4 final register sweep");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule